// File: doc/BRIEF.md
# Four-Channel Power Rail Sequencer

This controller switches four supply rails on and off, each through an external switch whose gate it commands. Turn-on starts only once the enable is active, every rail-OK flag is true and the shared system-reset bus is released, and those conditions have then held for a fixed lockout time. After that, all four on-delay timers start together. Each rail's gate command rises when its own programmed delay expires, so the delay values alone set the order. Turn-off works the same way: when the enable goes away, all four off-delay timers start together with no lockout.

Once every gate reports fully enhanced, a settling timer runs, and only then is the sequence-complete output raised. A fault removes every gate at once and holds all gates on their hard pull-down. A fault is a rail-OK flag dropping, or the system-reset bus going low, while any rail is being driven. A release of the system-reset bus while everything else is satisfied starts the turn-on at once, without the lockout. Restart after a fault or a disable is automatic.

All timing is counted in ticks from a shared clock prescaler. Analog gate drive and comparators are outside the block. The inputs are expected to be already filtered and synchronous to the clock.

Top module: `rail_seq_ctrl`

## Requirements
- R1: The enable counts as active when `en_in` equals `EN_ACTIVE_HIGH`. Turn-on needs the enable active, all four `rail_ok` bits at 1 and `bus_ok_in` at 1, held for `LOCK_TICKS` ticks. The lockout is entered on the clock edge that first samples these conditions. Losing any condition during the lockout returns the block to waiting with all gates off, and the full lockout restarts when the conditions come back.
- R2: One tick is `TICK_DIV` clocks. The on phase begins `LOCK_TICKS*TICK_DIV+1` cycles after the lockout is entered, and all four on-delays start at that moment. `gate_on[i]` rises `d*TICK_DIV+1` cycles after the on phase begins, where d is `on_dly[i*DLY_W +: DLY_W]`.
- R3: A channel with a delay of 0 changes its gate command one cycle after its phase begins: after the lockout for turn-on, and after the disable for turn-off.
- R4: `seq_done` rises only after all four `gate_on` and all four `gate_full` bits are 1. The settle phase starts one cycle after both are seen. `seq_done` goes high `SETTLE_TICKS*TICK_DIV+1` cycles after the settle phase starts. `seq_done` is never high unless all gates are on.
- R5: If the enable goes inactive while no fault is present, `seq_done` is low from the next edge. The off phase begins on that same edge. `gate_on[i]` falls `d*TICK_DIV+1` cycles after the off phase begins, where d is `off_dly[i*DLY_W +: DLY_W]`. A gate command falls only in the off phase or through a fault.
- R6: A channel whose gate command is low shows `gate_fast_off[i]` = 1 exactly while `gate_low[i]` is 1 (hard pull-down). Before that it shows 0 (slow discharge). `gate_low` reaches the output in the same cycle.
- R7: A fault causes all `gate_on` to be 0, all `gate_fast_off` to be 1 and `seq_done` to be 0 from the next edge. A fault is a `rail_ok` bit at 0 or `bus_ok_in` at 0 during the on phase, the settle phase, the fully-on state or the off phase.
- R8: Suppose `bus_ok_in` was 0 in the previous cycle and is 1 now, with the enable active and all rails OK. Then the lockout is skipped and the on phase begins at the next edge.
- R9: After a fault, the block returns to the lockout by itself on the first edge where all start conditions hold again. The forced fast-off flags are released on that edge.
- R10: An enable that becomes active again during the off phase does not stop it. After the last gate has dropped, the block waits one cycle and then enters a new lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Sequence enable, polarity set by EN_ACTIVE_HIGH |
| rail_ok | input | NCH | Filtered rail above-undervoltage flags, 1 = OK |
| bus_ok_in | input | 1 | Filtered level of the shared system-reset bus, 1 = released |
| on_dly | input | NCH*DLY_W | Per-channel turn-on delay in ticks, channel i at [i*DLY_W +: DLY_W] |
| off_dly | input | NCH*DLY_W | Per-channel turn-off delay in ticks, same packing |
| gate_full | input | NCH | Gate i has reached full enhancement |
| gate_low | input | NCH | Gate i has fallen to the hard pull-down threshold |
| gate_on | output | NCH | Gate i turn-on command |
| gate_fast_off | output | NCH | Gate i hard pull-down command |
| seq_done | output | 1 | Sequence complete, high when all rails are on and settled |

## Verification
Every result has a fixed latency. A phase begins one edge after its trigger is sampled. A gate changes d*TICK_DIV+1 cycles after its phase begins. The lockout and the settle phase each last their tick count times TICK_DIV plus one cycle. Faults act on the next edge, and the fast-off flag follows `gate_low` in the same cycle. When the bench drives a stimulus, it computes the absolute cycle number of each result and queues the expected value under that cycle. Just before and just after each gate transition it also queues the values that must hold. The monitor compares each entry 2 ns after the edge with the matching cycle count, so every result is checked exactly in its own cycle and never one edge early or late.

// File: rtl/rseq_pkg.sv
// Shared types for the rail sequencer.
package rseq_pkg;
    // Sequencer phases, in the order a normal power cycle visits them.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOCKOUT   = 3'd1,
        ST_RAMP_ON   = 3'd2,
        ST_SETTLE    = 3'd3,
        ST_ON        = 3'd4,
        ST_RAMP_OFF  = 3'd5,
        ST_FAULT_OFF = 3'd6
    } seq_state_t;
endpackage

// File: rtl/rseq_tick.sv
// Tick prescaler: one-cycle tick every DIV clocks.
// Assumes restart is pulsed on every phase change so that each phase
// sees its first tick exactly DIV cycles after it begins.
module rseq_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] pre_cnt;

    // Tick fires on the last count of each period.
    assign tick = (pre_cnt == CW'(DIV - 1));

    // Prescale counter, cleared on restart and on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rseq_fsm.sv
// Sequencer control: phase state machine plus the single phase timer
// shared by lockout, on phase, settle and off phase.
// Assumes all inputs are synchronous and already deglitched.
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int CW           = 24,
    parameter int LOCK_TICKS   = 10000,
    parameter int SETTLE_TICKS = 160000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           en_act,
    input  logic [NCH-1:0] rail_ok,
    input  logic           bus_ok,
    input  logic [NCH-1:0] gate_on,
    input  logic [NCH-1:0] gate_full,
    output seq_state_t     state,
    output logic [CW-1:0]  ph_cnt,
    output logic           phase_start,
    output logic           fault_hit
);
    seq_state_t state_nxt;
    logic       bus_prev;
    logic       cond_ok;
    logic       active;
    logic       lock_done;
    logic       settle_done;
    logic       all_up;

    // Start conditions and fault detection.
    always_comb begin
        cond_ok     = en_act && (&rail_ok) && bus_ok;
        active      = (state == ST_RAMP_ON) || (state == ST_SETTLE) ||
                      (state == ST_ON) || (state == ST_RAMP_OFF);
        fault_hit   = active && (!(&rail_ok) || !bus_ok);
        lock_done   = (ph_cnt >= CW'(LOCK_TICKS));
        settle_done = (ph_cnt >= CW'(SETTLE_TICKS));
        all_up      = (&gate_on) && (&gate_full);
    end

    // Next-phase decision; fault outranks disable.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_FAULT_OFF: begin
                if (cond_ok) begin
                    state_nxt = bus_prev ? ST_LOCKOUT : ST_RAMP_ON;
                end
            end
            ST_LOCKOUT: begin
                if (!cond_ok)       state_nxt = ST_IDLE;
                else if (lock_done) state_nxt = ST_RAMP_ON;
            end
            ST_RAMP_ON: begin
                if (fault_hit)      state_nxt = ST_FAULT_OFF;
                else if (!en_act)   state_nxt = ST_RAMP_OFF;
                else if (all_up)    state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (fault_hit)        state_nxt = ST_FAULT_OFF;
                else if (!en_act)     state_nxt = ST_RAMP_OFF;
                else if (settle_done) state_nxt = ST_ON;
            end
            ST_ON: begin
                if (fault_hit)      state_nxt = ST_FAULT_OFF;
                else if (!en_act)   state_nxt = ST_RAMP_OFF;
            end
            ST_RAMP_OFF: begin
                if (fault_hit)            state_nxt = ST_FAULT_OFF;
                else if (gate_on == '0)   state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign phase_start = (state_nxt != state);

    // Phase register and bus history for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bus_prev <= 1'b1;
        end else begin
            state    <= state_nxt;
            bus_prev <= bus_ok;
        end
    end

    // Phase timer: cleared on each phase change, saturating tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_start) begin
            ph_cnt <= '0;
        end else if (tick && (ph_cnt != '1)) begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rseq_chan.sv
// One rail channel: compares the shared phase timer with its own on or
// off delay, latches the gate command, and derives the hard pull-down.
// Assumes only one of run_on / run_off is high at a time.
module rseq_chan #(
    parameter int DLY_W = 24,
    parameter int CW    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_on,
    input  logic             run_off,
    input  logic             kill,
    input  logic             in_fault,
    input  logic [CW-1:0]    ph_cnt,
    input  logic [DLY_W-1:0] on_dly,
    input  logic [DLY_W-1:0] off_dly,
    input  logic             gate_low,
    output logic             gate_on,
    output logic             fast_off
);
    logic [DLY_W-1:0] lim;
    logic             hit;

    // Delay selection and expiry compare.
    always_comb begin
        lim = run_off ? off_dly : on_dly;
        hit = (ph_cnt >= CW'(lim));
    end

    // Latched gate command: fault clears, expiry sets or clears per phase.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            gate_on <= 1'b0;
        end else if (run_on && hit) begin
            gate_on <= 1'b1;
        end else if (run_off && hit) begin
            gate_on <= 1'b0;
        end
    end

    // Hard pull-down once low enough, or at once during a fault.
    assign fast_off = !gate_on && (in_fault || gate_low);
endmodule

// File: rtl/rail_seq_ctrl.sv
// Four-channel power rail sequencer, top level.
// Wires the prescaler, the phase controller and one channel per rail.
// Assumes en_in, rail_ok, bus_ok_in, gate_full and gate_low are filtered
// and synchronous to clk.
module rail_seq_ctrl
    import rseq_pkg::*;
#(
    parameter int NCH            = 4,
    parameter int DLY_W          = 24,
    parameter int TICK_DIV       = 100,
    parameter int LOCK_TICKS     = 10000,
    parameter int SETTLE_TICKS   = 160000,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_in,
    input  logic [NCH-1:0]       rail_ok,
    input  logic                 bus_ok_in,
    input  logic [NCH*DLY_W-1:0] on_dly,
    input  logic [NCH*DLY_W-1:0] off_dly,
    input  logic [NCH-1:0]       gate_full,
    input  logic [NCH-1:0]       gate_low,
    output logic [NCH-1:0]       gate_on,
    output logic [NCH-1:0]       gate_fast_off,
    output logic                 seq_done
);
    localparam int TLIM = (LOCK_TICKS > SETTLE_TICKS) ? LOCK_TICKS : SETTLE_TICKS;
    localparam int TW   = $clog2(TLIM + 2);
    localparam int CW   = (DLY_W > TW) ? DLY_W : TW;

    seq_state_t    state;
    logic [CW-1:0] ph_cnt;
    logic          tick;
    logic          phase_start;
    logic          fault_hit;
    logic          en_act;
    logic          run_on;
    logic          run_off;
    logic          in_fault;

    // Enable polarity and per-phase channel controls.
    always_comb begin
        en_act   = (en_in == EN_ACTIVE_HIGH);
        run_on   = (state == ST_RAMP_ON);
        run_off  = (state == ST_RAMP_OFF);
        in_fault = (state == ST_FAULT_OFF);
        seq_done = (state == ST_ON);
    end

    rseq_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_start),
        .tick    (tick)
    );

    rseq_fsm #(
        .NCH          (NCH),
        .CW           (CW),
        .LOCK_TICKS   (LOCK_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .en_act      (en_act),
        .rail_ok     (rail_ok),
        .bus_ok      (bus_ok_in),
        .gate_on     (gate_on),
        .gate_full   (gate_full),
        .state       (state),
        .ph_cnt      (ph_cnt),
        .phase_start (phase_start),
        .fault_hit   (fault_hit)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        rseq_chan #(
            .DLY_W (DLY_W),
            .CW    (CW)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_on   (run_on),
            .run_off  (run_off),
            .kill     (fault_hit),
            .in_fault (in_fault),
            .ph_cnt   (ph_cnt),
            .on_dly   (on_dly[gi*DLY_W +: DLY_W]),
            .off_dly  (off_dly[gi*DLY_W +: DLY_W]),
            .gate_low (gate_low[gi]),
            .gate_on  (gate_on[gi]),
            .fast_off (gate_fast_off[gi])
        );
    end
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
// Property checker for rail_seq_ctrl, attached by bind below.
// Observes the phase register, the fault decision and the outputs.
module rail_seq_ctrl_chk
    import rseq_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input seq_state_t     state,
    input logic           fault_hit,
    input logic           en_act,
    input logic [NCH-1:0] gate_on,
    input logic [NCH-1:0] gate_fast_off,
    input logic           seq_done
);
    // R1: no gate is driven while waiting or in lockout.
    p_idle_gates_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_LOCKOUT)) |-> (gate_on == '0));

    // R2: a gate command rises only out of the on phase.
    p_rise_only_ramp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_on & ~$past(gate_on)) != '0) |-> ($past(state) == ST_RAMP_ON));

    // R4: completion implies every gate is on.
    p_done_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (&gate_on));

    // R4: completion is reached only through the settle phase.
    p_done_after_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> ($past(state) == ST_SETTLE));

    // R5: disable drops completion on the next edge.
    p_disable_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !en_act) |=> !seq_done);

    // R5: a gate command falls only in the off phase or through a fault.
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~gate_on & $past(gate_on)) != '0) |->
            (($past(state) == ST_RAMP_OFF) || $past(fault_hit)));

    // R7: a fault removes all gates at once through the hard pull-down.
    p_fault_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> ((gate_on == '0) && (&gate_fast_off) && !seq_done));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .fault_hit     (fault_hit),
    .en_act        (en_act),
    .gate_on       (gate_on),
    .gate_fast_off (gate_fast_off),
    .seq_done      (seq_done)
);

// File: tb/rail_seq_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output values by absolute
// cycle number, the monitor compares them 2 ns after each rising edge.
module rail_seq_ctrl_tb;
    localparam int NCH    = 4;
    localparam int DLY_W  = 24;
    localparam int DIV    = 2;
    localparam int LOCK   = 20;
    localparam int SETTLE = 30;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 en_in;
    logic [NCH-1:0]       rail_ok;
    logic                 bus_ok_in;
    logic [NCH*DLY_W-1:0] on_dly;
    logic [NCH*DLY_W-1:0] off_dly;
    logic [NCH-1:0]       gate_full;
    logic [NCH-1:0]       gate_low;
    logic [NCH-1:0]       gate_on;
    logic [NCH-1:0]       gate_fast_off;
    logic                 seq_done;

    rail_seq_ctrl #(
        .NCH            (NCH),
        .DLY_W          (DLY_W),
        .TICK_DIV       (DIV),
        .LOCK_TICKS     (LOCK),
        .SETTLE_TICKS   (SETTLE),
        .EN_ACTIVE_HIGH (1'b0)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_in         (en_in),
        .rail_ok       (rail_ok),
        .bus_ok_in     (bus_ok_in),
        .on_dly        (on_dly),
        .off_dly       (off_dly),
        .gate_full     (gate_full),
        .gate_low      (gate_low),
        .gate_on       (gate_on),
        .gate_fast_off (gate_fast_off),
        .seq_done      (seq_done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         cyc;
        int         kind;
        logic [3:0] val;
        int         req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_flag = 1'b0;

    // Queue an expected value, kept in cycle order.
    task automatic expect_at(input int k, input int kind, input logic [3:0] v, input int req);
        exp_t e;
        int   idx;
        e.cyc = k; e.kind = kind; e.val = v; e.req = req;
        idx = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > k) begin
                idx = i;
                break;
            end
        end
        q.insert(idx, e);
    endtask

    task automatic wait_cyc(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    // Bench enable is active low (EN_ACTIVE_HIGH = 0).
    task automatic set_en(input bit on);
        en_in = ~on;
    endtask

    // Monitor: compare every due entry after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t       e;
                logic [3:0] act;
                string      nm;
                e = q.pop_front();
                case (e.kind)
                    0:       begin act = gate_on;               nm = "gate_on";       end
                    1:       begin act = gate_fast_off;         nm = "gate_fast_off"; end
                    default: begin act = {3'b000, seq_done};    nm = "seq_done";      end
                endcase
                n_cmp++;
                if (act !== e.val || e.cyc != cyc) begin
                    n_bad++;
                    $display("FAIL R%0d cycle %0d (due %0d) %s actual %b expected %b",
                             e.req, cyc, e.cyc, nm, act, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d, expected end of test", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n, a, a2, m, b, a3, a4, r;
        rst_n     = 1'b0;
        set_en(1'b0);
        rail_ok   = 4'hF;
        bus_ok_in = 1'b1;
        gate_full = 4'h0;
        gate_low  = 4'h0;
        // ch3..ch0 delays in ticks
        on_dly    = {24'd1, 24'd5, 24'd0, 24'd3};
        off_dly   = {24'd1, 24'd0, 24'd4, 24'd2};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        n = cyc;

        // R1: reset state, and inactive enable (en_in = 1) starts nothing.
        expect_at(n + 1, 0, 4'b0000, 1);
        expect_at(n + 1, 1, 4'b0000, 1);
        expect_at(n + 1, 2, 4'b0000, 1);
        expect_at(n + 30, 0, 4'b0000, 1);
        wait_cyc(n + 30);

        // R1: lockout restarts after a rail drops out during it.
        set_en(1'b1);
        a = cyc + 1;
        expect_at(a + 42, 0, 4'b0000, 1);
        wait_cyc(a + 10);
        rail_ok = 4'b1101;
        wait_cyc(a + 15);
        rail_ok = 4'hF;
        a2 = a + 16;
        // R2 / R3: all on-delays start together after the lockout.
        expect_at(a2 + 41, 0, 4'b0000, 1);
        expect_at(a2 + 42, 0, 4'b0010, 3);
        expect_at(a2 + 43, 0, 4'b0010, 2);
        expect_at(a2 + 44, 0, 4'b1010, 2);
        expect_at(a2 + 47, 0, 4'b1010, 2);
        expect_at(a2 + 48, 0, 4'b1011, 2);
        expect_at(a2 + 51, 0, 4'b1011, 2);
        expect_at(a2 + 52, 0, 4'b1111, 2);
        // R4: no completion while gates are not reported full.
        expect_at(a2 + 59, 2, 4'b0000, 4);
        m = a2 + 60;
        expect_at(m + 61, 2, 4'b0000, 4);
        expect_at(m + 62, 2, 4'b0001, 4);
        wait_cyc(m);
        gate_full = 4'hF;

        // R5 / R6 / R3: disable and ordered turn-off.
        wait_cyc(a2 + 130);
        set_en(1'b0);
        b = cyc + 1;
        expect_at(b,     2, 4'b0000, 5);
        expect_at(b,     0, 4'b1111, 5);
        expect_at(b + 1, 0, 4'b1011, 3);
        expect_at(b + 2, 0, 4'b1011, 5);
        expect_at(b + 2, 1, 4'b0000, 6);
        expect_at(b + 3, 0, 4'b0011, 5);
        expect_at(b + 3, 1, 4'b1100, 6);
        expect_at(b + 5, 0, 4'b0010, 5);
        expect_at(b + 5, 1, 4'b1101, 6);
        expect_at(b + 8, 0, 4'b0010, 5);
        expect_at(b + 9, 0, 4'b0000, 5);
        expect_at(b + 9, 1, 4'b1111, 6);
        wait_cyc(b + 2);
        gate_low = 4'hF;

        // R7 / R9: rail fault in the fully-on state, then automatic restart.
        wait_cyc(b + 20);
        gate_low = 4'h0;
        set_en(1'b1);
        a3 = cyc + 1;
        expect_at(a3 + 52,  0, 4'b1111, 2);
        expect_at(a3 + 113, 2, 4'b0000, 4);
        expect_at(a3 + 114, 2, 4'b0001, 4);
        expect_at(a3 + 120, 0, 4'b1111, 7);
        expect_at(a3 + 121, 0, 4'b0000, 7);
        expect_at(a3 + 121, 1, 4'b1111, 7);
        expect_at(a3 + 121, 2, 4'b0000, 7);
        expect_at(a3 + 130, 1, 4'b1111, 7);
        expect_at(a3 + 131, 1, 4'b0000, 9);
        a4 = a3 + 131;
        expect_at(a4 + 41, 0, 4'b0000, 9);
        expect_at(a4 + 42, 0, 4'b0010, 9);
        wait_cyc(a3 + 120);
        rail_ok = 4'b1101;
        wait_cyc(a3 + 130);
        rail_ok = 4'hF;

        // R7 / R8: bus pulled low mid-ramp, then released with no lockout.
        wait_cyc(a4 + 45);
        bus_ok_in = 1'b0;
        expect_at(a4 + 46, 0, 4'b0000, 7);
        expect_at(a4 + 46, 1, 4'b1111, 7);
        wait_cyc(a4 + 50);
        bus_ok_in = 1'b1;
        r = a4 + 51;
        expect_at(r,      0, 4'b0000, 8);
        expect_at(r + 1,  0, 4'b0010, 8);
        expect_at(r + 3,  0, 4'b1010, 8);
        expect_at(r + 11, 0, 4'b1111, 8);
        expect_at(r + 73, 2, 4'b0001, 4);

        // R10: enable back during the off phase; the off phase completes first.
        wait_cyc(r + 80);
        set_en(1'b0);
        b = cyc + 1;
        expect_at(b + 8,  0, 4'b0010, 10);
        expect_at(b + 9,  0, 4'b0000, 10);
        expect_at(b + 52, 0, 4'b0000, 10);
        expect_at(b + 53, 0, 4'b0010, 10);
        wait_cyc(b + 2);
        set_en(1'b1);
        wait_cyc(b + 60);

        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule